// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down-counters behind a small word-addressed register port. Software programs a start value and a reload value for each counter, picks where its ticks come from (an external one-cycle reference tick, or the system clock divided by a power of two), and chooses between periodic and one-shot operation. When a counter expires it sets a sticky event flag in a shared status register and drives its own interrupt output high until software clears that flag.

Each counter is sequenced by a three-state machine. **ST_STOPPED** is the state after reset or while the enable bit is clear; the transition *arm* moves it to **ST_RUN** once the enable bit is set. In ST_RUN, *halt* returns to ST_STOPPED when the enable bit is cleared, and *expire-single* moves to **ST_SPENT** when the counter expires with reload off. ST_SPENT holds the counter at zero and raises no further events. The transition *rewrite* leaves it when software writes the value register, going to ST_RUN if the timer is enabled and to ST_STOPPED if it is not. A value write in ST_RUN also takes the *rewrite* path. In periodic mode the counter reloads on expiry and remains in ST_RUN.

The register offsets in bytes are as follows: 0x00 control, 0x04 status, 0x10/0x14 reload/value of timer 0, and 0x18/0x1C reload/value of timer 1. The port takes word addresses, so these are words 0, 1, 4, 5, 6 and 7. Unmapped words read as zero.

Top module: `dual_dntimer`

## Requirements
- R1: After reset every register reads 0 and both interrupt outputs are low.
- R2: The control word keeps only its defined bits: timer 0 enable at bit 0 and reload at bit 1, timer 1 enable at bit 2 and reload at bit 3, timer 0 fixed-tick select at bit 11, timer 1 fixed-tick select at bit 12, timer 0 prescale in bits 21:19, and timer 1 prescale in bits 24:22. All other bits read back as 0, so the mask is 0x01F8180F.
- R3: With the fixed-tick select bit set, an enabled running counter decrements by one on each cycle in which `ref_tick` is high. Between ticks it holds its value. The other timer is unaffected.
- R4: With the fixed-tick select bit clear, a counter with prescale field d ticks once every 2^d system clock cycles. A field of 5 divides by 32.
- R5: With reload enabled and N-1 written to both the reload and value registers, the timer expires once every N ticks and loads the reload value on expiry.
- R6: With reload value 0xFFFFFFFF and reload enabled, a counter at 0 wraps to 0xFFFFFFFF on its next tick and then continues to 0xFFFFFFFE.
- R7: With reload disabled, the counter expires on the tick where it is 0 and then holds at 0 with no new events. A write to the value register loads the counter directly and rearms it.
- R8: Timer 0 flags in status bit 0 and timer 1 in bit 8. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged.
- R9: `irq[i]` follows the flag of timer i: it rises on expiry and stays high until software clears the flag.
- R10: Clearing a timer's enable bit freezes its counter on the next edge and leaves the status flags untouched.
- R11: When an expiry and a software clear of the same flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ref_tick | input | 1 | One-cycle fixed reference tick enable shared by both timers |
| irq | output | 2 | Per-timer interrupt, bit i for timer i |

## Verification
The bench drives every counting test from `ref_tick` so that values are fully predictable, and it uses the prescaled source only for interval measurements between interrupt rises. Several corner cases get their own checks:
- A one-shot timer that kept counting or fired again after expiry would show a changed value or a flag returning after a clear.
- A reload path off by one would give a period of N-1 or N+1 ticks and miss the wrap to 0xFFFFFFFF.
- A design that let the clear win over a simultaneous expiry would lose the flag.
- A status write that treated 1 as clear, or a disable that also wiped the flags, shows up as a wrong status readback.
- A prescaler with the wrong exponent shows up as an interval other than 16, 64 or 5 cycles.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
    localparam int NUM_TMR   = 2;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int PSC_W     = 3;
    localparam int PSC_CNT_W = (1 << PSC_W) - 1;

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUN     = 2'd1,
        ST_SPENT   = 2'd2
    } tmr_state_t;

    function automatic int en_pos(input int i);
        return 2 * i;
    endfunction

    function automatic int rl_pos(input int i);
        return 2 * i + 1;
    endfunction

    function automatic int fix_pos(input int i);
        return 11 + i;
    endfunction

    function automatic int psc_pos(input int i);
        return 19 + PSC_W * i;
    endfunction

    function automatic int flag_pos(input int i);
        return 8 * i;
    endfunction

    function automatic logic [ADDR_W-1:0] rld_addr(input int i);
        return ADDR_W'(4 + 2 * i);
    endfunction

    function automatic logic [ADDR_W-1:0] val_addr(input int i);
        return ADDR_W'(5 + 2 * i);
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            m[en_pos(i)]  = 1'b1;
            m[rl_pos(i)]  = 1'b1;
            m[fix_pos(i)] = 1'b1;
            for (int b = 0; b < PSC_W; b++) begin
                m[psc_pos(i) + b] = 1'b1;
            end
        end
        return m;
    endfunction
endpackage

// File: rtl/dtim_prescale.sv
module dtim_prescale #(
    parameter int PSC_W = 3,
    localparam int CNT_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W:0]   cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    logic             restart;

    always_comb begin
        lim     = ~({CNT_W{1'b1}} << div);
        restart = ({en, div} != cfg_q);
        tick    = en && !restart && (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
        end else begin
            cfg_q <= {en, div};
            if (restart || !en || (cnt_q == lim)) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_PSC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div != '0)) |=> !tick); // R4
endmodule

// File: rtl/dtim_counter.sv
module dtim_counter
    import dtim_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         reload_en,
    input  logic         tick,
    input  logic [W-1:0] reload_val,
    input  logic         val_we,
    input  logic [W-1:0] val_wdata,
    output logic [W-1:0] value,
    output logic         expire
);
    tmr_state_t   state_q, state_d;
    logic [W-1:0] value_d;
    logic         count_tick;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (val_we)                   state_d = en ? ST_RUN : ST_STOPPED;
                else if (!en)                 state_d = ST_STOPPED;
                else if (expire && !reload_en) state_d = ST_SPENT;
            end
            ST_SPENT: begin
                if (val_we) state_d = en ? ST_RUN : ST_STOPPED;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        count_tick = (state_q == ST_RUN) && en && tick && !val_we;
        expire     = count_tick && (value == '0);
        value_d    = value;
        if (val_we) begin
            value_d = val_wdata;
        end else if (count_tick) begin
            if (value != '0)     value_d = value - W'(1);
            else if (reload_en)  value_d = reload_val;
            else                 value_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) value <= '0;
        else        value <= value_d;
    end

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !val_we) |=> $stable(value)); // R10
    AST_DECR: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && en && tick && !val_we && (value != '0))
        |=> (value == $past(value) - W'(1))); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_en) |=> (value == $past(reload_val))); // R5
    AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SPENT) && !val_we) |-> (!expire && (value == '0))); // R7
endmodule

// File: rtl/dual_dntimer.sv
module dual_dntimer
    import dtim_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic [NUM_TMR-1:0] irq
);
    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rld_q   [NUM_TMR];
    logic [DATA_W-1:0] value_w [NUM_TMR];
    logic [NUM_TMR-1:0] flag_q;
    logic [NUM_TMR-1:0] expire_w;
    logic [NUM_TMR-1:0] psc_tick;
    logic [NUM_TMR-1:0] sel_tick;
    logic [NUM_TMR-1:0] val_we;
    logic               stat_we;

    assign stat_we = bus_we && (bus_addr == A_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (bus_we && (bus_addr == A_CTRL)) ctrl_q <= bus_wdata & CTRL_MASK;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        logic             t_en;
        logic [PSC_W-1:0] t_div;

        assign t_en      = ctrl_q[en_pos(g)];
        assign t_div     = ctrl_q[psc_pos(g) +: PSC_W];
        assign sel_tick[g] = ctrl_q[fix_pos(g)] ? ref_tick : psc_tick[g];
        assign val_we[g] = bus_we && (bus_addr == val_addr(g));

        dtim_prescale #(.PSC_W(PSC_W)) u_psc (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (t_en),
            .div  (t_div),
            .tick (psc_tick[g])
        );

        dtim_counter #(.W(DATA_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (t_en),
            .reload_en (ctrl_q[rl_pos(g)]),
            .tick      (sel_tick[g]),
            .reload_val(rld_q[g]),
            .val_we    (val_we[g]),
            .val_wdata (bus_wdata),
            .value     (value_w[g]),
            .expire    (expire_w[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   rld_q[g] <= '0;
            else if (bus_we && (bus_addr == rld_addr(g))) rld_q[g] <= bus_wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  flag_q[g] <= 1'b0;
            else if (expire_w[g])                        flag_q[g] <= 1'b1;
            else if (stat_we && !bus_wdata[flag_pos(g)]) flag_q[g] <= 1'b0;
        end

        AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            expire_w[g] |=> flag_q[g]); // R11
        AST_WR1_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_we && bus_wdata[flag_pos(g)] && !expire_w[g])
            |=> (flag_q[g] == $past(flag_q[g]))); // R8
        AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[g] && !stat_we) |=> irq[g]); // R9
    end

    assign irq = flag_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) bus_rdata = ctrl_q;
        if (bus_addr == A_STAT) begin
            for (int i = 0; i < NUM_TMR; i++) bus_rdata[flag_pos(i)] = flag_q[i];
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (bus_addr == rld_addr(i)) bus_rdata = rld_q[i];
            if (bus_addr == val_addr(i)) bus_rdata = value_w[i];
        end
    end
endmodule

// File: tb/dual_dntimer_bench.sv
module dual_dntimer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic [1:0]  irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dual_dntimer u_dual_dntimer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .ref_tick (ref_tick),
        .irq      (irq)
    );

    // Monitor: compares read data one step after the edge that follows the request.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                total++;
                if (bus_rdata !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got=%08h exp=%08h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; ref_tick = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ref_tick = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic pin_chk(input logic got, input logic e, input string tag);
        total++;
        if (got !== e) begin
            bad++;
            $display("FAIL %s: got=%0b exp=%0b", tag, got, e);
        end
    endtask

    task automatic val_chk(input int got, input int e, input string tag);
        total++;
        if (got != e) begin
            bad++;
            $display("FAIL %s: got=%0d exp=%0d", tag, got, e);
        end
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
    endtask

    task automatic rise_time(output int t);
        t = -1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (irq[0]) begin
                t = cyc;
                break;
            end
        end
        wr(3'd1, 32'h0);
    endtask

    task automatic interval_chk(input int e, input string tag);
        int t0, t1, t2;
        rise_time(t0);
        rise_time(t1);
        rise_time(t2);
        val_chk(t1 - t0, e, tag);
        val_chk(t2 - t1, e, tag);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got=timeout exp=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        pin_chk(irq[0], 1'b0, "R1 irq0");
        pin_chk(irq[1], 1'b0, "R1 irq1");
        rd_chk(3'd0, 32'h0, "R1 ctrl");
        rd_chk(3'd1, 32'h0, "R1 status");
        rd_chk(3'd5, 32'h0, "R1 value0");
        rd_chk(3'd6, 32'h0, "R1 reload1");

        // R2 control mask
        wr(3'd0, 32'hFFFF_FFF0);
        rd_chk(3'd0, 32'h01F8_1800, "R2 ctrl mask");
        wr(3'd0, 32'h0);
        rd_chk(3'd2, 32'h0, "R2 unmapped");

        // R3 / R7 one-shot on reference tick
        wr(3'd5, 32'd3);
        wr(3'd0, 32'h0000_0801);
        ticks(3);
        rd_chk(3'd5, 32'd0, "R3 value0 after 3 ticks");
        rd_chk(3'd1, 32'h0, "R7 no flag before zero tick");
        ticks(1);
        rd_chk(3'd1, 32'h1, "R7 flag on zero tick");
        pin_chk(irq[0], 1'b1, "R9 irq0 set");
        ticks(2);
        rd_chk(3'd5, 32'd0, "R7 holds zero");
        pin_chk(irq[0], 1'b1, "R9 irq0 held");
        wr(3'd1, 32'h0);
        rd_chk(3'd1, 32'h0, "R8 write zero clears");
        pin_chk(irq[0], 1'b0, "R9 irq0 cleared");
        ticks(2);
        rd_chk(3'd1, 32'h0, "R7 no new event when spent");
        wr(3'd5, 32'd1);
        ticks(1);
        rd_chk(3'd5, 32'd0, "R7 rearmed counts");
        ticks(1);
        rd_chk(3'd1, 32'h1, "R7 rearmed expires");

        // R8 write one keeps
        wr(3'd1, 32'hFFFF_FFFF);
        rd_chk(3'd1, 32'h1, "R8 write one keeps");

        // R11 expiry beats clear
        wr(3'd5, 32'd0);
        wr_tick(3'd1, 32'h0);
        rd_chk(3'd1, 32'h1, "R11 expiry wins");

        // R10 disable keeps flags
        wr(3'd0, 32'h0);
        rd_chk(3'd1, 32'h1, "R10 flags kept on disable");
        wr(3'd1, 32'h0);

        // R5 periodic timer1 on reference tick
        wr(3'd6, 32'd2);
        wr(3'd7, 32'd2);
        wr(3'd0, 32'h0000_100C);
        ticks(3);
        rd_chk(3'd1, 32'h100, "R5 timer1 flag at bit 8");
        rd_chk(3'd7, 32'd2, "R5 reloaded");
        pin_chk(irq[1], 1'b1, "R9 irq1 set");
        pin_chk(irq[0], 1'b0, "R3 irq0 idle");
        rd_chk(3'd5, 32'd0, "R3 timer0 unaffected");
        wr(3'd1, 32'hFFFF_FEFF);
        rd_chk(3'd1, 32'h0, "R8 clear bit 8");
        ticks(1);
        rd_chk(3'd7, 32'd1, "R5 mid period");
        rd_chk(3'd1, 32'h0, "R5 no early event");
        ticks(2);
        rd_chk(3'd1, 32'h100, "R5 second period");
        rd_chk(3'd7, 32'd2, "R5 reloaded again");

        // R10 freeze
        ticks(1);
        wr(3'd0, 32'h0000_1008);
        ticks(3);
        rd_chk(3'd7, 32'd1, "R10 frozen value");
        rd_chk(3'd1, 32'h100, "R10 flag untouched");
        wr(3'd1, 32'h0);

        // R6 wrap
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0);
        wr(3'd0, 32'h0000_0803);
        ticks(1);
        rd_chk(3'd5, 32'hFFFF_FFFF, "R6 wrap");
        rd_chk(3'd1, 32'h1, "R6 wrap event");
        ticks(1);
        rd_chk(3'd5, 32'hFFFF_FFFE, "R6 continue");

        // R4 prescaled source
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd4, 32'd3);
        wr(3'd5, 32'd3);
        wr(3'd0, (32'd2 << 19) | 32'h3);
        interval_chk(16, "R4 div4 period4");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'd1);
        wr(3'd5, 32'd1);
        wr(3'd0, (32'd5 << 19) | 32'h3);
        interval_chk(64, "R4 div32 period2");
        wr(3'd0, 32'h0);
        wr(3'd4, 32'd4);
        wr(3'd5, 32'd4);
        wr(3'd0, 32'h3);
        interval_chk(5, "R4 div1 period5");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule